// File: doc/BRIEF.md
# Pipelined Compare Tag RAM

This block is a synchronous tag store whose word is split into byte lanes (two lanes of nine bits by default). It serves ordinary reads and per-lane writes. It also holds its own compare operand, which it checks against the stored word on every cycle. Address, write data and every control are captured at a rising clock edge. The word at the captured address is then both read out and compared, and both results are registered at the following edge.

The compare operand has its own load enable. Fill writes can therefore put new tags into the array without disturbing the operand being matched. A deselected cycle reports a hit, so that several of these blocks can be placed side by side to extend depth. The hit output and the read data are each gated by their own output enable. These enables act without a clock.

Top module: `tag_cmp_ram`

## Requirements
- R1: The block is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A cycle captured while deselected writes nothing into the array and leaves the compare operand unchanged.
- R2: Lane j covers bits [9j+8:9j], so lane 0 is bits 8:0 and lane 1 is bits 17:9. In a selected cycle, lane j is written when `all_wr_n`=0, or when `bw_gate_n`=0 and `byte_wr_n[j]`=0. While `bw_gate_n`=1 and `all_wr_n`=1, `byte_wr_n` has no effect and the cycle is a read.
- R3: The compare operand takes `wdata` when `cmp_ld_n`=0 in a selected cycle, whether that cycle reads or writes. A write with `cmp_ld_n`=1 (a fill) updates the array and leaves the operand unchanged.
- R4: For a cycle captured at edge k, the hit result compares the operand after edge k with the word stored at the captured address before that cycle's own write. The result becomes visible just after edge k+1.
- R5: `hit` is 1 when the stored word equals the operand in all lanes, and 0 otherwise.
- R6: A deselected cycle produces `hit`=1. After reset, `hit` is 1.
- R7: While `hit_oe_n`=1, `hit`=0 and `hit_drv`=0. While `hit_oe_n`=0, `hit_drv`=1. Both respond without a clock.
- R8: A selected cycle that writes no lane is a read. After edge k+1, `rd_data` holds the stored word and `rd_valid`=1, provided `rd_oe_n`=0. After write cycles, deselected cycles, reset, or while `rd_oe_n`=1, `rd_valid`=0 and `rd_data`=0.
- R9: A write captured at edge k lands in the array at edge k+1. A later read of that address returns the new lanes and the old contents of the unwritten lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline registers |
| addr | input | AW (8) | Word address |
| wdata | input | W (18) | Write data and compare operand source |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| byte_wr_n | input | NB (2) | Per-lane write strobes, active low |
| bw_gate_n | input | 1 | Qualifies the lane strobes, active low |
| all_wr_n | input | 1 | Writes every lane, active low |
| cmp_ld_n | input | 1 | Compare operand load enable, active low |
| rd_oe_n | input | 1 | Read data output enable, active low |
| hit_oe_n | input | 1 | Hit output enable, active low |
| rd_data | output | W (18) | Registered read word, 0 when not valid |
| rd_valid | output | 1 | Read data is being driven |
| hit | output | 1 | Registered compare result |
| hit_drv | output | 1 | Hit output is being driven |

## Verification
On every cycle, the assertions check four things. Both output enables silence their outputs. A deselected or unqualified cycle neither writes nor loads the operand. A deselect always yields a hit two edges later. A captured write never raises the read-valid flag. The value-level behaviour can only be shown by the directed scenarios. This covers lane merging, the fill write that keeps an older operand, and the write cycle that compares against the word it is about to replace. It also covers the equality result against real stored words.

// File: rtl/tcr_pkg.sv
`timescale 1ns/1ps
package tcr_pkg;

   // Captured cycle kind, carried from the front stage to the result stage
   typedef struct packed {
      logic sel;   // cycle was selected
      logic rd;    // selected and no lane written
   } cyc_t;

   function automatic logic chip_sel(input logic a_n, input logic b, input logic c_n);
      return !a_n && b && !c_n;
   endfunction

endpackage

// File: rtl/tcr_front.sv
`timescale 1ns/1ps
module tcr_front #(
   parameter int AW = 8,
   parameter int BW = 9,
   parameter int NB = 2,
   localparam int W = BW * NB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr,
   input  logic [W-1:0]      wdata,
   input  logic              cs_a_n,
   input  logic              cs_b,
   input  logic              cs_c_n,
   input  logic [NB-1:0]     byte_wr_n,
   input  logic              bw_gate_n,
   input  logic              all_wr_n,
   input  logic              cmp_ld_n,
   output logic [AW-1:0]     addr_q,
   output logic [W-1:0]      data_q,
   output logic [NB-1:0]     we_q,
   output tcr_pkg::cyc_t     cyc_q,
   output logic [W-1:0]      opnd_q
);
   logic          sel;
   logic [NB-1:0] we_nxt;

   assign sel = tcr_pkg::chip_sel(cs_a_n, cs_b, cs_c_n);

   // lane write gating: global strobe wins, lane strobes need the gate
   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign we_nxt[g] = sel && (!all_wr_n || (!bw_gate_n && !byte_wr_n[g]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         we_q   <= '0;
         cyc_q  <= '0;
      end else begin
         addr_q    <= addr;
         data_q    <= wdata;
         we_q      <= we_nxt;
         cyc_q.sel <= sel;
         cyc_q.rd  <= sel && (we_nxt == '0);
      end
   end

   // compare operand: own enable, independent of the write path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                opnd_q <= '0;
      else if (sel && !cmp_ld_n) opnd_q <= wdata;
   end

   AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_ld_n || !sel) |=> $stable(opnd_q)); // R3
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (all_wr_n && bw_gate_n) |=> (we_q == '0)); // R2
   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> ((we_q == '0) && !cyc_q.rd)); // R1

endmodule

// File: rtl/tcr_array.sv
`timescale 1ns/1ps
module tcr_array #(
   parameter int DEPTH = 256,
   parameter int BW    = 9,
   parameter int NB    = 2,
   localparam int AW   = $clog2(DEPTH),
   localparam int W    = BW * NB
) (
   input  logic            clk,
   input  logic [AW-1:0]   addr_q,
   input  logic [W-1:0]    data_q,
   input  logic [NB-1:0]   we_q,
   output logic [W-1:0]    word
);
   logic [W-1:0] mem [DEPTH];

   // read is combinational from the captured address: old word before the write
   assign word = mem[addr_q];

   always_ff @(posedge clk) begin
      for (int j = 0; j < NB; j++) begin
         if (we_q[j]) mem[addr_q][j*BW +: BW] <= data_q[j*BW +: BW];
      end
   end

endmodule

// File: rtl/tcr_match.sv
`timescale 1ns/1ps
module tcr_match #(
   parameter int BW = 9,
   parameter int NB = 2,
   localparam int W = BW * NB
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   word,
   input  logic [W-1:0]   opnd,
   input  tcr_pkg::cyc_t  cyc,
   output logic           match_q,
   output logic [W-1:0]   rd_q,
   output logic           rdv_q
);
   logic [NB-1:0] lane_eq;

   for (genvar g = 0; g < NB; g++) begin : g_eq
      assign lane_eq[g] = (word[g*BW +: BW] == opnd[g*BW +: BW]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b1;
         rd_q    <= '0;
         rdv_q   <= 1'b0;
      end else begin
         match_q <= cyc.sel ? (&lane_eq) : 1'b1;
         rdv_q   <= cyc.rd;
         if (cyc.rd) rd_q <= word;
      end
   end

   AST_RDV_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc.sel |=> !rdv_q); // R8

endmodule

// File: rtl/tag_cmp_ram.sv
`timescale 1ns/1ps
module tag_cmp_ram #(
   parameter int DEPTH = 256,
   parameter int BW    = 9,
   parameter int NB    = 2,
   localparam int AW   = $clog2(DEPTH),
   localparam int W    = BW * NB
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   addr,
   input  logic [W-1:0]    wdata,
   input  logic            cs_a_n,
   input  logic            cs_b,
   input  logic            cs_c_n,
   input  logic [NB-1:0]   byte_wr_n,
   input  logic            bw_gate_n,
   input  logic            all_wr_n,
   input  logic            cmp_ld_n,
   input  logic            rd_oe_n,
   input  logic            hit_oe_n,
   output logic [W-1:0]    rd_data,
   output logic            rd_valid,
   output logic            hit,
   output logic            hit_drv
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("tag_cmp_ram: DEPTH must be at least 2");
   end
   if (BW < 1 || NB < 1) begin : g_bad_lane
      $error("tag_cmp_ram: lane width and lane count must be positive");
   end

   logic [AW-1:0]  addr_q;
   logic [W-1:0]   data_q;
   logic [NB-1:0]  we_q;
   tcr_pkg::cyc_t  cyc_q;
   logic [W-1:0]   opnd_q;
   logic [W-1:0]   word;
   logic           match_q;
   logic [W-1:0]   rd_q;
   logic           rdv_q;

   tcr_front #(.AW(AW), .BW(BW), .NB(NB)) u_front (
      .clk, .rst_n, .addr, .wdata, .cs_a_n, .cs_b, .cs_c_n,
      .byte_wr_n, .bw_gate_n, .all_wr_n, .cmp_ld_n,
      .addr_q, .data_q, .we_q, .cyc_q, .opnd_q
   );

   tcr_array #(.DEPTH(DEPTH), .BW(BW), .NB(NB)) u_array (
      .clk, .addr_q, .data_q, .we_q, .word
   );

   tcr_match #(.BW(BW), .NB(NB)) u_match (
      .clk, .rst_n, .word, .opnd(opnd_q), .cyc(cyc_q),
      .match_q, .rd_q, .rdv_q
   );

   // unclocked output enables
   assign hit_drv  = !hit_oe_n;
   assign hit      = !hit_oe_n && match_q;
   assign rd_valid = !rd_oe_n && rdv_q;
   assign rd_data  = rd_valid ? rd_q : '0;

   AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hit_oe_n |-> (!hit && !hit_drv)); // R7
   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0)); // R8
   AST_DESEL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !tcr_pkg::chip_sel(cs_a_n, cs_b, cs_c_n) |=> ##1 (hit_oe_n || hit)); // R6
   AST_WR_NO_RDV: assert property (@(posedge clk) disable iff (!rst_n)
      (tcr_pkg::chip_sel(cs_a_n, cs_b, cs_c_n) && !all_wr_n) |=> ##1 !rd_valid); // R8

endmodule

// File: tb/test_tag_cmp_ram.sv
`timescale 1ns/1ps
module test_tag_cmp_ram;
   localparam int DEPTH = 256;
   localparam int AW = 8;
   localparam int W  = 18;

   logic clk = 1'b0;
   logic rst_n;
   logic [AW-1:0] addr;
   logic [W-1:0] wdata;
   logic cs_a_n, cs_b, cs_c_n;
   logic [1:0] byte_wr_n;
   logic bw_gate_n, all_wr_n, cmp_ld_n, rd_oe_n, hit_oe_n;
   logic [W-1:0] rd_data;
   logic rd_valid, hit, hit_drv;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] mem_m [16];
   logic         known [16];
   logic [W-1:0] opnd_m;

   always #2 clk = ~clk;   // 250 MHz

   tag_cmp_ram #(.DEPTH(DEPTH), .BW(9), .NB(2)) i_tag_cmp_ram (
      .clk, .rst_n, .addr, .wdata, .cs_a_n, .cs_b, .cs_c_n,
      .byte_wr_n, .bw_gate_n, .all_wr_n, .cmp_ld_n, .rd_oe_n, .hit_oe_n,
      .rd_data, .rd_valid, .hit, .hit_drv
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      cs_a_n = 1'b1; cs_b = 1'b1; cs_c_n = 1'b0;
      byte_wr_n = 2'b11; bw_gate_n = 1'b1; all_wr_n = 1'b1; cmp_ld_n = 1'b1;
      addr = '0; wdata = '0;
   endtask

   // one cycle with expectations computed from the requirements
   task automatic op(string req, int a, logic [W-1:0] d, logic [1:0] bn,
                     logic bg, logic gw, logic ld,
                     logic ca, logic cb, logic cc);
      logic sel;
      logic [1:0] we;
      logic [W-1:0] op_new;
      logic exp_hit;
      logic hit_known;
      sel = !ca && cb && !cc;                                   // R1
      for (int j = 0; j < 2; j++) we[j] = sel && (!gw || (!bg && !bn[j])); // R2
      op_new = (sel && !ld) ? d : opnd_m;                        // R3
      hit_known = !sel || known[a];
      exp_hit = sel ? (mem_m[a] == op_new) : 1'b1;               // R4 R5 R6
      addr = AW'(a); wdata = d; byte_wr_n = bn; bw_gate_n = bg;
      all_wr_n = gw; cmp_ld_n = ld; cs_a_n = ca; cs_b = cb; cs_c_n = cc;
      @(posedge clk); #1;
      idle();
      @(posedge clk); #1;
      if (hit_known) chk({req, " hit"}, 32'(hit), 32'(exp_hit));
      chk({req, " R8 rd_valid"}, 32'(rd_valid), 32'(sel && we == 2'b00));
      if (sel && we == 2'b00) chk({req, " R9 rd_data"}, 32'(rd_data), 32'(mem_m[a]));
      if (we[0]) mem_m[a][8:0]  = d[8:0];
      if (we[1]) mem_m[a][17:9] = d[17:9];
      if (we == 2'b11) known[a] = 1'b1;
      opnd_m = op_new;
   endtask

   task automatic t_reset();
      chk("R6 hit after reset", 32'(hit), 32'd1);
      chk("R7 hit_drv enabled", 32'(hit_drv), 32'd1);
      chk("R8 rd_valid after reset", 32'(rd_valid), 32'd0);
   endtask

   task automatic t_fill_and_read();
      for (int a = 0; a < 4; a++)
         op("R9 fill", a, 18'h01234 ^ W'(a * 18'h0A5A5), 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      for (int a = 0; a < 4; a++)
         op("R5 equal", a, mem_m[a], 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      op("R5 mismatch", 1, mem_m[1] ^ 18'h00100, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      op("R5 mismatch hi lane", 1, mem_m[1] ^ 18'h20000, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_fill_keeps_operand();
      op("R3 load", 2, mem_m[2], 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      op("R3 fill write", 3, 18'h3C3C3, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      op("R3 operand kept", 2, 18'h0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_write_compare_old();
      op("R4 write vs old word", 2, 18'h2AAAA, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      op("R4 next sees new word", 2, 18'h0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_lanes();
      op("R2 low lane", 1, 18'h3FFFF, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      op("R2 read low", 1, 18'h0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      op("R2 high lane", 0, 18'h15555, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      op("R2 read high", 0, 18'h0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      op("R2 strobes ungated", 3, 18'h00000, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      op("R2 read after ungated", 3, 18'h0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_deselect();
      op("R1 load operand", 3, mem_m[3], 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      op("R6 desel a", 3, 18'h11111, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      op("R6 desel b", 3, 18'h22222, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      op("R6 desel c", 3, 18'h03333, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      op("R1 no write no load", 3, 18'h0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_enables();
      op("R7 setup", 0, mem_m[0], 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      hit_oe_n = 1'b1; #0.5;
      chk("R7 hit off", 32'(hit), 32'd0);
      chk("R7 hit_drv off", 32'(hit_drv), 32'd0);
      hit_oe_n = 1'b0; #0.5;
      chk("R7 hit back", 32'(hit), 32'd1);
      rd_oe_n = 1'b1; #0.5;
      chk("R8 rd_valid off", 32'(rd_valid), 32'd0);
      chk("R8 rd_data zero", 32'(rd_data), 32'd0);
      rd_oe_n = 1'b0; #0.5;
      chk("R8 rd_data back", 32'(rd_data), 32'(mem_m[0]));
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin mem_m[i] = '0; known[i] = 1'b0; end
      opnd_m = '0;
      idle();
      rd_oe_n = 1'b0; hit_oe_n = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_fill_and_read();
      t_fill_keeps_operand();
      t_write_compare_old();
      t_lanes();
      t_deselect();
      t_enables();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule